// File: doc/BRIEF.md
# Link Self-Test Error Statistics

This block keeps the running statistics of a serial-link loopback self-test. A receive path hands it one strobe per received test frame, together with a CRC-error flag and a DWORD-error flag for that frame. A mode input says whether DWORD checking is active. From these the block keeps three counts. The first counts every received test frame. The second counts frames that carry a CRC error. The third counts burst errors, which are DWORD errors spaced at least a holdoff window of frames apart.

No count ever wraps: each one holds at its all-ones value. The asynchronous global reset clears every count. So do two synchronous inputs, a port reset and a software count-clear pulse. Each count is available on its own registered read-only bus. The block holds no register decode, so the surrounding logic decides how the buses are read.

Top module: `link_bist_stats`

## Requirements
- R1: Each cycle with `frame_vld_i` high adds one to `frame_cnt_o` (FRAME_W bits, default 32). The new value appears after the next rising clock edge, and all outputs come straight from registers.
- R2: No count wraps. `frame_cnt_o` holds at all-ones (FFFF_FFFFh by default), `crc_cnt_o` holds at all-ones (FFFFh by default) and `burst_cnt_o` holds at all-ones (FFh by default).
- R3: `rst_ni` low clears every count asynchronously. `port_rst_i` or `cnt_clr_i` high clears every count at the next edge. A clear wins over a frame strobe in the same cycle, so the counts read zero afterwards.
- R4: `crc_cnt_o` adds one for each cycle in which both `frame_vld_i` and `crc_err_i` are high. `crc_err_i` without `frame_vld_i` has no effect.
- R5: With `dw_mode_i` high, the first frame with `dw_err_i` after any reset or clear is counted as a burst at once.
- R6: After a counted burst, a later DWORD error is counted only when at least HOLDOFF frames (default 27000) have been received in DWORD mode since the counted burst frame. An error on the HOLDOFF-th such frame is ignored, and an error on the next frame is counted.
- R7: A DWORD error ignored inside the holdoff window does not restart the window.
- R8: While `dw_mode_i` is low, `burst_cnt_o` and the holdoff window tracking stay frozen. Frame and CRC counting continue.
- R9: The frames-since-burst tracker holds at HOLDOFF. After any longer error-free run, the next DWORD error is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low global reset |
| port_rst_i | input | 1 | Synchronous port reset, clears all counts |
| cnt_clr_i | input | 1 | Synchronous software count-clear pulse |
| frame_vld_i | input | 1 | One received test frame this cycle |
| crc_err_i | input | 1 | Frame carries a CRC error (qualified by frame_vld_i) |
| dw_err_i | input | 1 | Frame carries a DWORD error (qualified by frame_vld_i) |
| dw_mode_i | input | 1 | DWORD checking mode active |
| frame_cnt_o | output | FRAME_W | Received frame count |
| crc_cnt_o | output | CRC_W | CRC-error frame count |
| burst_cnt_o | output | BURST_W | Burst-error count |

## Verification
The only hidden state is the holdoff tracker and its first-error flag. A fault in either shows on `burst_cnt_o` only when the next DWORD error arrives. A tracker that restarts or advances wrongly moves the counted burst by one or more frames, so the bench places errors exactly on the HOLDOFF-th and the next frame, and across mode-off gaps. A wrong saturation or clear shows at the next edge on the affected count bus.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
  localparam int unsigned DEF_FRAME_W = 32;
  localparam int unsigned DEF_CRC_W   = 16;
  localparam int unsigned DEF_BURST_W = 8;
  localparam int unsigned DEF_HOLDOFF = 27000;

  typedef struct packed {
    logic frame;
    logic crc;
    logic dw;
    logic mode;
  } rx_evt_t;
endpackage

// File: rtl/bist_sat_ctr.sv
module bist_sat_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && (cnt_q != MAX)) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + W'(1));
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bist_burst_gate.sv
module bist_burst_gate #(
  parameter int unsigned HOLDOFF = 27000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic frame_i,
  input  logic err_i,
  output logic hit_o
);
  localparam int unsigned GAP_W = $clog2(HOLDOFF + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(HOLDOFF);

  logic [GAP_W-1:0] gap_q;
  logic             first_q;
  logic             open;

  // window open: nothing counted yet, or holdoff elapsed
  assign open  = first_q || (gap_q >= GAP_MAX);
  assign hit_o = frame_i && err_i && open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      first_q <= 1'b1;
    end else if (clr_i) begin
      gap_q   <= '0;
      first_q <= 1'b1;
    end else if (hit_o) begin
      gap_q   <= '0;
      first_q <= 1'b0;
    end else if (frame_i && !first_q && gap_q != GAP_MAX) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  a_r9_gap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_MAX);
  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !clr_i) |=> (gap_q == '0 && !first_q));
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && err_i && !hit_o && !clr_i && gap_q != GAP_MAX)
      |=> gap_q == $past(gap_q) + GAP_W'(1));
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !clr_i) |=> ($stable(gap_q) && $stable(first_q)));
endmodule

// File: rtl/link_bist_stats.sv
module link_bist_stats
  import link_bist_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W,
  parameter int unsigned CRC_W   = DEF_CRC_W,
  parameter int unsigned BURST_W = DEF_BURST_W,
  parameter int unsigned HOLDOFF = DEF_HOLDOFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               port_rst_i,
  input  logic               cnt_clr_i,
  input  logic               frame_vld_i,
  input  logic               crc_err_i,
  input  logic               dw_err_i,
  input  logic               dw_mode_i,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic [CRC_W-1:0]   crc_cnt_o,
  output logic [BURST_W-1:0] burst_cnt_o
);
  rx_evt_t evt;
  logic    clr;
  logic    burst_hit;

  assign evt = '{frame: frame_vld_i, crc: crc_err_i, dw: dw_err_i, mode: dw_mode_i};
  assign clr = port_rst_i | cnt_clr_i;

  bist_sat_ctr #(.W(FRAME_W)) u_frame_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (evt.frame),
    .cnt_o (frame_cnt_o)
  );

  bist_sat_ctr #(.W(CRC_W)) u_crc_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (evt.frame & evt.crc),
    .cnt_o (crc_cnt_o)
  );

  bist_burst_gate #(.HOLDOFF(HOLDOFF)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .frame_i(evt.frame & evt.mode),
    .err_i  (evt.dw),
    .hit_o  (burst_hit)
  );

  bist_sat_ctr #(.W(BURST_W)) u_burst_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (burst_hit),
    .cnt_o (burst_cnt_o)
  );

  a_r8_mode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dw_mode_i && !clr) |=> $stable(burst_cnt_o));
  a_r4_crc_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_vld_i && !clr) |=> ($stable(crc_cnt_o) && $stable(frame_cnt_o)));
  a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (frame_cnt_o == '0 && crc_cnt_o == '0 && burst_cnt_o == '0));
  a_r5_first_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr) |=> (frame_vld_i && dw_err_i && dw_mode_i && !clr
               && burst_cnt_o == '0) |=> burst_cnt_o == BURST_W'(1));
endmodule

// File: tb/link_bist_stats_bench.sv
module link_bist_stats_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic port_rst = 1'b0, cnt_clr = 1'b0;
  logic frame_vld = 1'b0, crc_err = 1'b0, dw_err = 1'b0, dw_mode = 1'b0;

  logic [31:0] frame_cnt;
  logic [15:0] crc_cnt;
  logic [7:0]  burst_cnt;
  logic [9:0]  s_frame;
  logic [3:0]  s_crc;
  logic [2:0]  s_burst;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  link_bist_stats u_link_bist_stats (
    .clk_i(clk), .rst_ni(rst_ni), .port_rst_i(port_rst), .cnt_clr_i(cnt_clr),
    .frame_vld_i(frame_vld), .crc_err_i(crc_err), .dw_err_i(dw_err),
    .dw_mode_i(dw_mode), .frame_cnt_o(frame_cnt), .crc_cnt_o(crc_cnt),
    .burst_cnt_o(burst_cnt)
  );

  // reduced-size copy for saturation and tracker-hold corners
  link_bist_stats #(.FRAME_W(10), .CRC_W(4), .BURST_W(3), .HOLDOFF(4)) u_link_bist_stats_sat (
    .clk_i(clk), .rst_ni(rst_ni), .port_rst_i(port_rst), .cnt_clr_i(cnt_clr),
    .frame_vld_i(frame_vld), .crc_err_i(crc_err), .dw_err_i(dw_err),
    .dw_mode_i(dw_mode), .frame_cnt_o(s_frame), .crc_cnt_o(s_crc),
    .burst_cnt_o(s_burst)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_clear();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic frames(input int n, input logic crc, input logic dw);
    if (n > 0) begin
      @(negedge clk);
      frame_vld = 1'b1; crc_err = crc; dw_err = dw;
      repeat (n - 1) @(negedge clk);
      @(posedge clk);
      #1;
      frame_vld = 1'b0; crc_err = 1'b0; dw_err = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R3 reset frame", frame_cnt, 0);
    chk("R3 reset crc", crc_cnt, 0);
    chk("R3 reset burst", burst_cnt, 0);
  endtask

  task automatic t_basic();
    do_clear();
    dw_mode = 1'b0;
    @(negedge clk); frame_vld = 1'b1;
    @(negedge clk); frame_vld = 1'b0;
    chk("R1 one frame after edge", frame_cnt, 1);
    @(negedge clk);
    chk("R1 no double count", frame_cnt, 1);
    frames(6, 1'b0, 1'b0);
    frames(3, 1'b1, 1'b0);
    @(negedge clk); crc_err = 1'b1;
    @(negedge clk); crc_err = 1'b0;
    chk("R1 frame count", frame_cnt, 10);
    chk("R4 crc count, unqualified flag ignored", crc_cnt, 3);
  endtask

  task automatic t_holdoff_edge();
    do_clear();
    dw_mode = 1'b1;
    frames(1, 1'b0, 1'b1);
    chk("R5 first error immediate", burst_cnt, 1);
    frames(26999, 1'b0, 1'b0);
    frames(1, 1'b0, 1'b1);
    chk("R6 error on 27000th frame ignored", burst_cnt, 1);
    frames(1, 1'b0, 1'b1);
    chk("R6 error on 27001st frame counted", burst_cnt, 2);
    chk("R1 frames in run", frame_cnt, 27002);
  endtask

  task automatic t_no_restart();
    do_clear();
    dw_mode = 1'b1;
    frames(1, 1'b0, 1'b1);
    frames(9, 1'b0, 1'b0);
    frames(1, 1'b0, 1'b1);
    chk("R7 inside-window error ignored", burst_cnt, 1);
    frames(26990, 1'b0, 1'b0);
    frames(1, 1'b0, 1'b1);
    chk("R7 window not restarted", burst_cnt, 2);
  endtask

  task automatic t_mode_off();
    do_clear();
    dw_mode = 1'b0;
    frames(3, 1'b1, 1'b1);
    chk("R8 no burst with mode off", burst_cnt, 0);
    chk("R8 crc counts with mode off", crc_cnt, 3);
    dw_mode = 1'b1;
    frames(1, 1'b0, 1'b1);
    chk("R5 first error after mode on", burst_cnt, 1);
    frames(26999, 1'b0, 1'b0);
    dw_mode = 1'b0;
    frames(5, 1'b0, 1'b1);
    chk("R8 burst frozen mode off", burst_cnt, 1);
    dw_mode = 1'b1;
    frames(1, 1'b0, 1'b1);
    chk("R8 window frozen while mode off", burst_cnt, 1);
    frames(1, 1'b0, 1'b1);
    chk("R6 counted once window elapsed", burst_cnt, 2);
  endtask

  task automatic t_clear_wins();
    dw_mode = 1'b1;
    frames(4, 1'b1, 1'b1);
    @(negedge clk); frame_vld = 1'b1; crc_err = 1'b1; cnt_clr = 1'b1;
    @(negedge clk); frame_vld = 1'b0; crc_err = 1'b0; cnt_clr = 1'b0;
    chk("R3 clear wins frame", frame_cnt, 0);
    chk("R3 clear wins crc", crc_cnt, 0);
    frames(2, 1'b0, 1'b1);
    @(negedge clk); port_rst = 1'b1;
    @(negedge clk); port_rst = 1'b0;
    chk("R3 port reset frame", frame_cnt, 0);
    chk("R3 port reset burst", burst_cnt, 0);
    frames(3, 1'b0, 1'b0);
    @(negedge clk); rst_ni = 1'b0;
    #1;
    chk("R3 async reset frame", frame_cnt, 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_saturate();
    do_clear();
    dw_mode = 1'b1;
    frames(1030, 1'b1, 1'b1);
    chk("R2 frame holds at max", s_frame, 1023);
    chk("R2 crc holds at max", s_crc, 15);
    chk("R2 burst holds at max", s_burst, 7);
    chk("R2 main crc count", crc_cnt, 1030);
  endtask

  task automatic t_gap_hold();
    do_clear();
    dw_mode = 1'b1;
    frames(1, 1'b0, 1'b1);
    frames(20, 1'b0, 1'b0);
    frames(1, 1'b0, 1'b1);
    chk("R9 tracker held, error counted", s_burst, 2);
    frames(3, 1'b0, 1'b0);
    frames(1, 1'b0, 1'b1);
    chk("R6 small window 4th frame ignored", s_burst, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_holdoff_edge();
    t_no_restart();
    t_mode_off();
    t_clear_wins();
    t_saturate();
    t_gap_hold();
    finish_run();
  end
endmodule